// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block is the register-access front end of a multi-function I/O device. It watches byte reads and writes on a small host bus. Two adjacent addresses form its window: the lower one is an index port and the one above it is a data port. The configuration space stays shut until a fixed key byte is written to the index port a set number of times in a row. It shuts again when an exit byte is written to the index port.

While the space is open, the index port selects a register and the data port reads or writes it. One register picks the logical device. The device registers at index 0x30 and above then refer only to that device's private bank. Each bank holds:
- an activate bit;
- two 16-bit base addresses;
- an IRQ number, a trigger/polarity byte and a mode byte.

A group of global bytes at indices 0x20 to 0x2F is shared by every device. All bank contents and the global bytes leave the block as parallel outputs, so the device functions outside it can use them. Reads are combinational on the same cycle as the read strobe.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the configuration space is closed, and every device bank and every global byte is 0x00. The register index and the selected device number are also 0x00.
- R2: The space opens only after the key byte (0x87) is written to the index port twice with no other bus write in between. Any of the following restarts the count: an index write of another value, or any data-port write.
- R3: Writing the exit byte (0xAA) to the index port while the space is open closes it. That write does not change the register index.
- R4: While the space is closed, writes to the data port change no register and no output. A read of the index port or the data port returns 0xFF.
- R5: The index port sits at CFG_BASE and the data port at CFG_BASE+1. Accesses to any other address have no effect. While open, a read of the index port returns the last index written.
- R6: Register 0x07 holds the selected logical device number. It reads back as written.
- R7: Register 0x30 bit 0 drives the selected device's active output. The other bits of 0x30 are not stored and read as 0.
- R8: Registers 0x60 (high byte) and 0x61 (low byte) form the device's first base address. Registers 0x62 and 0x63 form the second base address in the same way.
- R9: Register 0x70 holds the device's IRQ number, register 0x71 its trigger/polarity byte (0x02 meaning active-high edge), and register 0xF0 its mode byte. All three are full bytes, exported per device.
- R10: Indices 0x20 to 0x2F are global bytes. They read and write the same storage whichever device is selected.
- R11: With a device number of NUM_LDEV or above selected, writes to banked registers change nothing and banked reads return 0x00. Unimplemented indices read 0x00 for any device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host byte address |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid while host_rd is high |
| cfg_open | output | 1 | Configuration space is open |
| dev_active | output | NUM_LDEV | Activate bit of each device |
| dev_base0 | output | NUM_LDEV x 16 | First base address of each device |
| dev_base1 | output | NUM_LDEV x 16 | Second base address of each device |
| dev_irq | output | NUM_LDEV x 8 | IRQ number of each device |
| dev_trig | output | NUM_LDEV x 8 | Trigger/polarity byte of each device |
| dev_mode | output | NUM_LDEV x 8 | Mode byte of each device |
| glob_regs | output | 16 x 8 | Global bytes at indices 0x20 to 0x2F |

## Verification
The hardest state to reach is a key count that has been partly built and then broken. A single key byte followed by a stray data write or a different index byte must leave the space shut. Only a later unbroken pair may open it. The stimulus interleaves such broken sequences before the real pair, and each time checks that the space is still closed and that a data-port read still returns 0xFF.

A second hard case is an index value held across an exit and re-entry. The bench sets an index, exits, writes the data port while closed, and reopens. It then reads the data port and expects the value written before the exit, not the stray write.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    // Register indices that the decoder recognises
    localparam logic [7:0] IDX_LDN   = 8'h07;
    localparam logic [7:0] IDX_ACT   = 8'h30;
    localparam logic [7:0] IDX_B0H   = 8'h60;
    localparam logic [7:0] IDX_B0L   = 8'h61;
    localparam logic [7:0] IDX_B1H   = 8'h62;
    localparam logic [7:0] IDX_B1L   = 8'h63;
    localparam logic [7:0] IDX_IRQ   = 8'h70;
    localparam logic [7:0] IDX_TRIG  = 8'h71;
    localparam logic [7:0] IDX_MODE  = 8'hF0;
    localparam logic [3:0] GLOB_HI   = 4'h2;
    localparam int         NUM_GLOB  = 16;

    typedef enum logic [3:0] {
        FLD_NONE,
        FLD_LDN,
        FLD_GLOB,
        FLD_ACT,
        FLD_B0H,
        FLD_B0L,
        FLD_B1H,
        FLD_B1L,
        FLD_IRQ,
        FLD_TRIG,
        FLD_MODE
    } cfg_field_e;

    typedef struct packed {
        logic        act;
        logic [15:0] base0;
        logic [15:0] base1;
        logic [7:0]  irq;
        logic [7:0]  trig;
        logic [7:0]  mode;
    } ldev_cfg_t;

    typedef struct packed {
        logic       wr_idx;
        logic       wr_dat;
        logic       rd_idx;
        logic       rd_dat;
        logic [7:0] data;
    } host_op_t;

    function automatic cfg_field_e decode_index(logic [7:0] idx);
        cfg_field_e f;
        unique case (idx)
            IDX_LDN:  f = FLD_LDN;
            IDX_ACT:  f = FLD_ACT;
            IDX_B0H:  f = FLD_B0H;
            IDX_B0L:  f = FLD_B0L;
            IDX_B1H:  f = FLD_B1H;
            IDX_B1L:  f = FLD_B1L;
            IDX_IRQ:  f = FLD_IRQ;
            IDX_TRIG: f = FLD_TRIG;
            IDX_MODE: f = FLD_MODE;
            default:  f = (idx[7:4] == GLOB_HI) ? FLD_GLOB : FLD_NONE;
        endcase
        return f;
    endfunction

    function automatic logic is_banked(cfg_field_e f);
        return (f != FLD_NONE) && (f != FLD_LDN) && (f != FLD_GLOB);
    endfunction

endpackage

// File: rtl/sio_host_decode.sv
module sio_host_decode
    import sio_cfg_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CFG_BASE = 12'h370
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output host_op_t          op
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = CFG_BASE + ADDR_W'(1);

    logic hit_idx, hit_dat;

    always_comb begin
        hit_idx   = (host_addr == CFG_BASE);
        hit_dat   = (host_addr == DATA_ADDR);
        op.wr_idx = host_wr & hit_idx;
        op.wr_dat = host_wr & hit_dat;
        op.rd_idx = host_rd & hit_idx;
        op.rd_dat = host_rd & hit_dat;
        op.data   = host_wdata;
    end
endmodule

// File: rtl/sio_unlock_fsm.sv
module sio_unlock_fsm
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] KEY        = 8'h87,
    parameter logic [7:0] EXIT       = 8'hAA,
    parameter int         KEY_REPEAT = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  host_op_t op,
    output logic     cfg_open
);
    localparam int CNT_W = $clog2(KEY_REPEAT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_REPEAT - 1);

    logic [CNT_W-1:0] key_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_open <= 1'b0;
            key_cnt  <= '0;
        end else if (!cfg_open) begin
            if (op.wr_idx) begin
                if (op.data == KEY) begin
                    if (key_cnt == LAST) begin
                        cfg_open <= 1'b1;
                        key_cnt  <= '0;
                    end else begin
                        key_cnt <= key_cnt + CNT_W'(1);
                    end
                end else begin
                    key_cnt <= '0;
                end
            end else if (op.wr_dat) begin
                key_cnt <= '0;
            end
        end else if (op.wr_idx && op.data == EXIT) begin
            cfg_open <= 1'b0;
        end
    end
endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] EXIT = 8'hAA
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_open,
    input  host_op_t                 op,
    output logic [7:0]               index,
    output logic [7:0]               ldn,
    output cfg_field_e               field,
    output logic [NUM_GLOB-1:0][7:0] glob
);
    always_comb field = decode_index(index);

    always_ff @(posedge clk) begin
        if (rst) begin
            index <= '0;
            ldn   <= '0;
            glob  <= '0;
        end else if (cfg_open) begin
            if (op.wr_idx && op.data != EXIT)
                index <= op.data;
            if (op.wr_dat) begin
                if (field == FLD_LDN)
                    ldn <= op.data;
                if (field == FLD_GLOB)
                    glob[index[3:0]] <= op.data;
            end
        end
    end
endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  cfg_field_e field,
    input  logic [7:0] wdata,
    output ldev_cfg_t  cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (field)
                FLD_ACT:  cfg.act         <= wdata[0];
                FLD_B0H:  cfg.base0[15:8] <= wdata;
                FLD_B0L:  cfg.base0[7:0]  <= wdata;
                FLD_B1H:  cfg.base1[15:8] <= wdata;
                FLD_B1L:  cfg.base1[7:0]  <= wdata;
                FLD_IRQ:  cfg.irq         <= wdata;
                FLD_TRIG: cfg.trig        <= wdata;
                FLD_MODE: cfg.mode        <= wdata;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] CFG_BASE   = 12'h370,
    parameter int                NUM_LDEV   = 9,
    parameter logic [7:0]        KEY        = 8'h87,
    parameter logic [7:0]        EXIT       = 8'hAA,
    parameter int                KEY_REPEAT = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             host_addr,
    input  logic                          host_wr,
    input  logic                          host_rd,
    input  logic [7:0]                    host_wdata,
    output logic [7:0]                    host_rdata,
    output logic                          cfg_open,
    output logic [NUM_LDEV-1:0]           dev_active,
    output logic [NUM_LDEV-1:0][15:0]     dev_base0,
    output logic [NUM_LDEV-1:0][15:0]     dev_base1,
    output logic [NUM_LDEV-1:0][7:0]      dev_irq,
    output logic [NUM_LDEV-1:0][7:0]      dev_trig,
    output logic [NUM_LDEV-1:0][7:0]      dev_mode,
    output logic [NUM_GLOB-1:0][7:0]      glob_regs
);
    host_op_t   op;
    logic [7:0] index, ldn;
    cfg_field_e field;
    ldev_cfg_t  bank [NUM_LDEV];
    ldev_cfg_t  sel_cfg;
    logic       bank_wr;

    sio_host_decode #(.ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE)) dec_i (
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_wdata(host_wdata),
        .op        (op)
    );

    sio_unlock_fsm #(.KEY(KEY), .EXIT(EXIT), .KEY_REPEAT(KEY_REPEAT)) key_i (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .cfg_open(cfg_open)
    );

    sio_global_regs #(.EXIT(EXIT)) glob_i (
        .clk     (clk),
        .rst     (rst),
        .cfg_open(cfg_open),
        .op      (op),
        .index   (index),
        .ldn     (ldn),
        .field   (field),
        .glob    (glob_regs)
    );

    always_comb bank_wr = cfg_open & op.wr_dat & is_banked(field);

    for (genvar d = 0; d < NUM_LDEV; d++) begin : g_bank
        sio_ldev_bank bank_i (
            .clk  (clk),
            .rst  (rst),
            .wr_en(bank_wr && (ldn == 8'(d))),
            .field(field),
            .wdata(op.data),
            .cfg  (bank[d])
        );
        assign dev_active[d] = bank[d].act;
        assign dev_base0[d]  = bank[d].base0;
        assign dev_base1[d]  = bank[d].base1;
        assign dev_irq[d]    = bank[d].irq;
        assign dev_trig[d]   = bank[d].trig;
        assign dev_mode[d]   = bank[d].mode;
    end

    // Bank of the selected device; zero when the number is out of range
    always_comb begin
        sel_cfg = '0;
        for (int d = 0; d < NUM_LDEV; d++)
            if (ldn == 8'(d))
                sel_cfg = bank[d];
    end

    always_comb begin
        host_rdata = 8'h00;
        if (op.rd_idx || op.rd_dat) begin
            if (!cfg_open) begin
                host_rdata = 8'hFF;
            end else if (op.rd_idx) begin
                host_rdata = index;
            end else begin
                case (field)
                    FLD_LDN:  host_rdata = ldn;
                    FLD_GLOB: host_rdata = glob_regs[index[3:0]];
                    FLD_ACT:  host_rdata = {7'b0, sel_cfg.act};
                    FLD_B0H:  host_rdata = sel_cfg.base0[15:8];
                    FLD_B0L:  host_rdata = sel_cfg.base0[7:0];
                    FLD_B1H:  host_rdata = sel_cfg.base1[15:8];
                    FLD_B1L:  host_rdata = sel_cfg.base1[7:0];
                    FLD_IRQ:  host_rdata = sel_cfg.irq;
                    FLD_TRIG: host_rdata = sel_cfg.trig;
                    FLD_MODE: host_rdata = sel_cfg.mode;
                    default:  host_rdata = 8'h00;
                endcase
            end
        end
    end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CFG_BASE = 12'h370,
    parameter int                NUM_LDEV = 9,
    parameter logic [7:0]        KEY      = 8'h87,
    parameter logic [7:0]        EXIT     = 8'hAA
) (
    input logic                      clk,
    input logic                      rst,
    input logic [ADDR_W-1:0]         host_addr,
    input logic                      host_wr,
    input logic                      host_rd,
    input logic [7:0]                host_wdata,
    input logic [7:0]                host_rdata,
    input logic                      cfg_open,
    input logic [NUM_LDEV-1:0]       dev_active,
    input logic [NUM_LDEV-1:0][15:0] dev_base0
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = CFG_BASE + ADDR_W'(1);

    p_open_after_key_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> $past(host_wr && host_addr == CFG_BASE && host_wdata == KEY));

    p_data_write_keeps_closed_r2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && host_wr && host_addr == DATA_ADDR) |=> !cfg_open);

    p_exit_closes_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && host_wr && host_addr == CFG_BASE && host_wdata == EXIT) |=> !cfg_open);

    p_closed_read_ff_r4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && host_rd && (host_addr == CFG_BASE || host_addr == DATA_ADDR))
        |-> host_rdata == 8'hFF);

    p_closed_write_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && host_wr && host_addr == DATA_ADDR)
        |=> ($stable(dev_active) && $stable(dev_base0)));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
    .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .NUM_LDEV(NUM_LDEV), .KEY(KEY), .EXIT(EXIT)
) chk_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cfg_open(cfg_open),
    .dev_active(dev_active), .dev_base0(dev_base0)
);

// File: tb/sio_cfg_port_tb_top.sv
module sio_cfg_port_tb_top;
    localparam int          ADDR_W = 12;
    localparam logic [11:0] BASE   = 12'h370;
    localparam logic [11:0] DATA   = 12'h371;
    localparam int          NLD    = 9;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [ADDR_W-1:0]      host_addr = '0;
    logic                   host_wr = 1'b0;
    logic                   host_rd = 1'b0;
    logic [7:0]             host_wdata = '0;
    logic [7:0]             host_rdata;
    logic                   cfg_open;
    logic [NLD-1:0]         dev_active;
    logic [NLD-1:0][15:0]   dev_base0, dev_base1;
    logic [NLD-1:0][7:0]    dev_irq, dev_trig, dev_mode;
    logic [15:0][7:0]       glob_regs;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    sio_cfg_port dut_i (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .cfg_open(cfg_open),
        .dev_active(dev_active), .dev_base0(dev_base0), .dev_base1(dev_base1),
        .dev_irq(dev_irq), .dev_trig(dev_trig), .dev_mode(dev_mode), .glob_regs(glob_regs)
    );

    function automatic logic [7:0] pat(int d, int r);
        return 8'(((d * 29) + (r * 7) + 3) ^ (r >> 1));
    endfunction

    function automatic logic [7:0] gpat(int i);
        return 8'((i * 13 + 5) ^ 8'hA5);
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] idx, input logic [7:0] d);
        wr(BASE, idx);
        wr(DATA, d);
    endtask

    task automatic rreg(input logic [7:0] idx, output logic [7:0] d);
        wr(BASE, idx);
        rd(DATA, d);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        int banked[8];
        banked = '{8'h30, 8'h60, 8'h61, 8'h62, 8'h63, 8'h70, 8'h71, 8'hF0};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(cfg_open, 0, "R1 open");
        chk(dev_active, 0, "R1 active");
        chk(dev_base0, 0, "R1 base0");
        chk(glob_regs, 0, "R1 glob");
        // R4 closed reads
        rd(BASE, rv); chk(rv, 8'hFF, "R4 idx read closed");
        rd(DATA, rv); chk(rv, 8'hFF, "R4 data read closed");

        // R2 broken sequences
        wr(BASE, 8'h87); wr(DATA, 8'h55); wr(BASE, 8'h87);
        chk(cfg_open, 0, "R2 data write breaks key");
        wr(BASE, 8'h12); wr(BASE, 8'h87);
        chk(cfg_open, 0, "R2 other index breaks key");
        rd(DATA, rv); chk(rv, 8'hFF, "R2 still closed read");
        wr(BASE, 8'h87);
        chk(cfg_open, 1, "R2 pair opens");

        // R5 index readback and foreign address
        wr(BASE, 8'h26);
        rd(BASE, rv); chk(rv, 8'h26, "R5 index readback");
        wr(12'h372, 8'hAA);
        chk(cfg_open, 1, "R5 foreign address ignored");
        rd(BASE, rv); chk(rv, 8'h26, "R5 index unchanged");

        // R6..R9 sweep all devices and banked registers
        for (int d = 0; d < NLD; d++) begin
            wreg(8'h07, 8'(d));
            for (int k = 0; k < 8; k++)
                wreg(8'(banked[k]), pat(d, banked[k]));
        end
        for (int d = 0; d < NLD; d++) begin
            wreg(8'h07, 8'(d));
            rreg(8'h07, rv); chk(rv, 8'(d), "R6 ldn readback");
            for (int k = 0; k < 8; k++) begin
                rreg(8'(banked[k]), rv);
                if (banked[k] == 8'h30) chk(rv, {7'b0, pat(d, 8'h30) & 8'h01}, "R7 act readback");
                else chk(rv, pat(d, banked[k]), "R8 R9 banked readback");
            end
            chk(dev_active[d], pat(d, 8'h30) & 8'h01, "R7 active out");
            chk(dev_base0[d], {pat(d, 8'h60), pat(d, 8'h61)}, "R8 base0 out");
            chk(dev_base1[d], {pat(d, 8'h62), pat(d, 8'h63)}, "R8 base1 out");
            chk(dev_irq[d], pat(d, 8'h70), "R9 irq out");
            chk(dev_trig[d], pat(d, 8'h71), "R9 trig out");
            chk(dev_mode[d], pat(d, 8'hF0), "R9 mode out");
        end

        // R10 globals shared
        wreg(8'h07, 8'd0);
        for (int i = 0; i < 16; i++) wreg(8'(8'h20 + i), gpat(i));
        wreg(8'h07, 8'd8);
        for (int i = 0; i < 16; i++) begin
            rreg(8'(8'h20 + i), rv); chk(rv, gpat(i), "R10 global shared");
        end
        chk(glob_regs[5], gpat(5), "R10 global out");

        // R11 out-of-range device and unimplemented index
        wreg(8'h07, 8'd9);
        wreg(8'h60, 8'hEE);
        rreg(8'h60, rv); chk(rv, 8'h00, "R11 out-of-range read");
        for (int d = 0; d < NLD; d++)
            chk(dev_base0[d], {pat(d, 8'h60), pat(d, 8'h61)}, "R11 no bank changed");
        wreg(8'h07, 8'd0);
        rreg(8'h50, rv); chk(rv, 8'h00, "R11 unimplemented index");

        // R9 trigger code active-high edge
        wreg(8'h07, 8'd3);
        wreg(8'h71, 8'h02);
        chk(dev_trig[3], 8'h02, "R9 trigger edge code");

        // R3 exit, R4 ignored write while closed
        wreg(8'h07, 8'd0);
        wr(BASE, 8'h70);
        wr(BASE, 8'hAA);
        chk(cfg_open, 0, "R3 exit closes");
        wr(DATA, 8'h33);
        chk(dev_irq[0], pat(0, 8'h70), "R4 closed write ignored");
        rd(DATA, rv); chk(rv, 8'hFF, "R4 closed read data");
        wr(BASE, 8'h87); wr(BASE, 8'h87);
        chk(cfg_open, 1, "R2 reopen");
        rd(BASE, rv); chk(rv, 8'h70, "R3 exit keeps index");
        rd(DATA, rv); chk(rv, pat(0, 8'h70), "R4 value kept over closed write");

        // R1 reset from populated state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(cfg_open, 0, "R1 reset closes");
        chk(dev_irq, 0, "R1 reset irq");
        chk(glob_regs, 0, "R1 reset glob");
        wr(BASE, 8'h87); wr(BASE, 8'h87);
        rd(BASE, rv); chk(rv, 8'h00, "R1 index reset");
        rreg(8'h07, rv); chk(rv, 8'h00, "R1 ldn reset");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule